// File: doc/BRIEF.md
# Erasable ROM Mode Model

This block is a synthesizable, clocked stand-in for a 64K-by-8 ultraviolet-erasable read-only memory. It is meant as a test target: a controller or programmer under test can drive it through the same control pins that a real part has. Supply and programming voltages are not modelled as analog levels. Two digital qualifier inputs stand for them instead. One marks the shared output-enable pin as raised to programming voltage. The other marks the identifier address line as raised to its high-voltage level.

Each clock cycle, the block decodes the control pins into one mode. The modes are read, output disable, standby, program, program inhibit and identifier. Program verify is a plain read. The data outputs and their tri-state enable are registered, so they reflect the inputs sampled at the previous edge.

The storage works like a fuse array. Programming can only clear bits. A synchronous erase input, and reset, return every cell to all ones. The number of cells held is a parameter, and the address is taken modulo that depth.

Top module: `uvrom_model`

## Requirements
- R1: After reset, and in the cycle after `erase` is high, every location reads 0xFF.
- R2: Each cycle with `vpp_hi`=1 and `ce_n`=0 replaces the addressed byte with (stored AND `din`), so a cleared bit never returns to 1.
- R3: With `vpp_hi`=1 and `ce_n`=1, the array is left unchanged and `dout_en` is 0 in the next cycle.
- R4: While programming (`vpp_hi`=1, `ce_n`=0), `dout_en` is 0 in the next cycle whatever `oe_n` is.
- R5: With `vpp_hi`=0, `ce_n`=0, `oe_n`=0 and `a9_hv`=0, the next cycle gives `dout_en`=1 and `dout` = the stored byte at the sampled address. This is also the verify read after programming.
- R6: With `vpp_hi`=0 and `ce_n`=1 (standby), `dout_en` is 0 in the next cycle.
- R7: With `vpp_hi`=0, `ce_n`=0 and `oe_n`=1 (output disable), `dout_en` is 0 in the next cycle.
- R8: A read with `a9_hv`=1 and every address bit other than bits 0 and 9 low returns a byte that depends on address bit 0. Bit 0 = 0 gives the maker byte 0xD5, and bit 0 = 1 gives the type byte 0x91. Both bytes have odd parity, with bit 7 as the parity bit.
- R9: A read with `a9_hv`=1 while any address bit other than bits 0 and 9 is high returns 0xFF with `dout_en`=1.
- R10: When `erase` and a program cycle coincide, the erase wins and the addressed byte reads 0xFF afterwards.
- R11: Only the low log2(DEPTH) address bits select a cell, so addresses that differ only above them share one byte.
- R12: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; erases the array |
| ce_n | input | 1 | Active-low chip select; its low level is the program pulse |
| oe_n | input | 1 | Active-low output enable (ignored while `vpp_hi` is set) |
| vpp_hi | input | 1 | Qualifier: output-enable pin is at programming voltage |
| a9_hv | input | 1 | Qualifier: address bit 9 is at identifier high voltage |
| addr | input | 16 | Byte address |
| din | input | 8 | Data to program |
| erase | input | 1 | Synchronous whole-array erase to all ones |
| dout | output | 8 | Registered read data, 0 when not driven |
| dout_en | output | 1 | Tri-state enable for `dout` |

## Verification
A corrupted cell, a lost AND in programming, or an erase that misses a location stays hidden until that exact address is read. It then appears in the output one cycle after the read is sampled. For this reason, the bench reads every location back after erase, and after each program step it reads the address it programmed. A wrong mode decode shows sooner: `dout_en` or `dout` will differ in the very next cycle. A reference model compares both signals on every clock, including during random mixed traffic.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_OUT_OFF,
        M_READ,
        M_IDENT,
        M_PROGRAM,
        M_INHIBIT
    } rom_mode_e;

endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
    import uvrom_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int HV_PIN  = 9,
    parameter int SEL_PIN = 0
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    output rom_mode_e         mode,
    output logic              id_legal,
    output logic              id_sel
);

    logic [ADDR_W-1:0] others;

    always_comb begin
        if (vpp_hi)      mode = ce_n ? M_INHIBIT : M_PROGRAM;
        else if (ce_n)   mode = M_STANDBY;
        else if (oe_n)   mode = M_OUT_OFF;
        else if (a9_hv)  mode = M_IDENT;
        else             mode = M_READ;
    end

    always_comb begin
        others          = addr;
        others[HV_PIN]  = 1'b0;
        others[SEL_PIN] = 1'b0;
        id_legal        = (others == '0);
        id_sel          = addr[SEL_PIN];
    end

endmodule

// File: rtl/uvrom_id_gen.sv
module uvrom_id_gen #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-2:0] MFR_LOW = 7'h55,
    parameter logic [DATA_W-2:0] DEV_LOW = 7'h11
) (
    input  logic              id_sel,
    input  logic              id_legal,
    output logic [DATA_W-1:0] id_byte
);

    // top bit chosen so that the whole byte has an odd count of ones
    localparam logic [DATA_W-1:0] MFR_BYTE = {~^MFR_LOW, MFR_LOW};
    localparam logic [DATA_W-1:0] DEV_BYTE = {~^DEV_LOW, DEV_LOW};

    always_comb begin
        if (!id_legal) id_byte = '1;
        else           id_byte = id_sel ? DEV_BYTE : MFR_BYTE;
    end

endmodule

// File: rtl/uvrom_cells.sv
module uvrom_cells #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '1;
        end else if (wr_en) begin
            mem_d[idx] = mem_q[idx] & wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[idx];

endmodule

// File: rtl/uvrom_model.sv
module uvrom_model
    import uvrom_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              en;
    } out_t;

    rom_mode_e         mode;
    logic              id_legal;
    logic              id_sel;
    logic [DATA_W-1:0] id_byte;
    logic [DATA_W-1:0] cell_byte;
    out_t              out_d, out_q;

    uvrom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .vpp_hi   (vpp_hi),
        .a9_hv    (a9_hv),
        .addr     (addr),
        .mode     (mode),
        .id_legal (id_legal),
        .id_sel   (id_sel)
    );

    uvrom_id_gen #(.DATA_W(DATA_W)) u_id (
        .id_sel   (id_sel),
        .id_legal (id_legal),
        .id_byte  (id_byte)
    );

    uvrom_cells #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (mode == M_PROGRAM),
        .idx     (addr[IDX_W-1:0]),
        .wr_data (din),
        .rd_data (cell_byte)
    );

    always_comb begin
        out_d = '0;
        unique case (mode)
            M_READ: begin
                out_d.en   = 1'b1;
                out_d.data = cell_byte;
            end
            M_IDENT: begin
                out_d.en   = 1'b1;
                out_d.data = id_byte;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout    = out_q.data;
    assign dout_en = out_q.en;

endmodule

// File: rtl/uvrom_checker.sv
module uvrom_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    logic rd_req;
    logic id_clean;

    always_comb begin
        rd_req   = !vpp_hi && !ce_n && !oe_n;
        id_clean = (addr[ADDR_W-1:10] == '0) && (addr[8:1] == '0);
    end

    p_vpp_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && ce_n) |=> !dout_en);

    p_prog_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !ce_n) |=> !dout_en);

    p_read_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> dout_en);

    p_standby_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && ce_n) |=> !dout_en);

    p_out_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && !ce_n && oe_n) |=> !dout_en);

    p_id_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && a9_hv && id_clean) |=> (^dout == 1'b1));

    p_id_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && a9_hv && !id_clean) |=> (dout == '1));

    p_quiet_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

endmodule

bind uvrom_model uvrom_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .a9_hv   (a9_hv),
    .addr    (addr),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/uvrom_model_tb.sv
module uvrom_model_tb;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] mdl [DEPTH];

    always #4 clk = ~clk;

    uvrom_model u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .addr(addr), .din(din), .erase(erase),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(string req, logic [7:0] ed, logic ee);
        total++;
        if (dout !== ed || dout_en !== ee) begin
            bad++;
            $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b",
                     req, dout, dout_en, ed, ee);
        end
    endtask

    // drive one cycle at the falling edge, model the rising edge, compare next falling edge
    task automatic cyc(string req, logic c, logic o, logic v, logic h,
                       logic [15:0] a, logic [7:0] d, logic e);
        logic [7:0] ed;
        logic       ee;
        ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; addr = a; din = d; erase = e;
        @(posedge clk);
        ed = 8'h00; ee = 1'b0;
        if (!v && !c && !o) begin
            ee = 1'b1;
            if (h) begin
                if ((a & 16'hFDFE) != 16'h0) ed = 8'hFF;
                else ed = a[0] ? 8'h91 : 8'hD5;
            end else begin
                ed = mdl[a % DEPTH];
            end
        end
        if (e) begin
            for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        end else if (v && !c) begin
            mdl[a % DEPTH] = mdl[a % DEPTH] & d;
        end
        @(negedge clk);
        check(req, ed, ee);
    endtask

    task automatic rd(string req, logic [15:0] a);
        cyc(req, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b0);
    endtask

    task automatic prog(string req, logic [15:0] a, logic [7:0] d);
        cyc(req, 1'b0, 1'b1, 1'b1, 1'b0, a, d, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check("R12 reset state", 8'h00, 1'b0);
        rst_n = 1'b1;

        // R1: fresh array reads all ones
        rd("R1", 16'h0000);
        rd("R1", 16'h00FF);
        rd("R1", 16'h0042);

        // R2: program ANDs into stored byte, verify read R5
        prog("R2", 16'h0005, 8'hA5);
        rd("R5 verify", 16'h0005);
        prog("R2", 16'h0005, 8'h5F);
        rd("R2", 16'h0005);
        prog("R2", 16'h0005, 8'hFF);
        rd("R2", 16'h0005);

        // R4: programming with oe_n low still keeps outputs off
        cyc("R4", 1'b0, 1'b0, 1'b1, 1'b0, 16'h0010, 8'h0F, 1'b0);
        rd("R4", 16'h0010);

        // R3: inhibit leaves the cell alone
        cyc("R3", 1'b1, 1'b0, 1'b1, 1'b0, 16'h0006, 8'h00, 1'b0);
        rd("R3", 16'h0006);

        // R6 standby, R7 output disable, R12 quiet output
        cyc("R6", 1'b1, 1'b0, 1'b0, 1'b0, 16'h0005, 8'h00, 1'b0);
        cyc("R7", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0005, 8'h00, 1'b0);
        cyc("R12", 1'b1, 1'b1, 1'b0, 1'b1, 16'h0200, 8'h00, 1'b0);

        // R8 identifier bytes, R9 illegal address lines
        cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0200, 8'h00, 1'b0);
        cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0201, 8'h00, 1'b0);
        cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b0);
        cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0202, 8'h00, 1'b0);
        cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 16'h8201, 8'h00, 1'b0);
        cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0400, 8'h00, 1'b0);

        // R11: aliasing above the depth
        prog("R11", 16'h0107, 8'h3C);
        rd("R11", 16'h0007);
        rd("R11", 16'hFF07);

        // R10: erase beats a coincident program
        cyc("R10", 1'b0, 1'b1, 1'b1, 1'b0, 16'h0005, 8'h00, 1'b1);
        rd("R10", 16'h0005);

        // R1: every location erased
        for (int i = 0; i < DEPTH; i++) rd("R1 sweep", 16'(i));

        // mixed random traffic, compared each clock (R2, R5)
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] k;
            k = 4'($urandom);
            cyc("R2 mix", k[0] & k[1], k[2], k[3] & ~k[0], ($urandom % 8) == 0,
                16'($urandom % 512) | (($urandom % 16 == 0) ? 16'h0200 : 16'h0),
                8'($urandom), ($urandom % 200) == 0);
        end
        for (int i = 0; i < DEPTH; i++) rd("R2 final", 16'(i));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule